// File: doc/BRIEF.md
# Free-running compare-match timer

A 32-bit time base with one match channel, attached to a simple synchronous register bus. An up-counter runs freely through its whole range and can be read at any moment without disturbing it, so software can use it as a clock. A match register is compared against the counter on every cycle while counting is on. When the two are equal and the match interrupt is enabled, a pending flag latches and the interrupt line rises.

Software schedules a single future event by reading the count, adding a delta and writing the sum to the match register. The wrap from all-ones to zero is part of normal counting, so a sum that overflows still fires after exactly the requested delta. Reading the interrupt register both reports and acknowledges the event.

While stopped, the counter continuously takes the start value. Setting the run bit resumes counting from that value.

Top module: `cmp_timer`

Register map (word addresses): 0 = control (bit 0 run), 1 = start value, 2 = count (read only), 3 = match, 4 = interrupt (bit 0 enable, writable; bit 1 pending, read only).

## Requirements
- R1: While the run bit (control bit 0) is set, the counter rises by one on every clock edge and goes from 0xFFFFFFFF to 0.
- R2: While the run bit is clear, no match is detected and the interrupt output stays low, even if the count equals the match register.
- R3: While the run bit is clear, the counter takes the start value register (address 1) on every edge; after the run bit is set, counting continues from that value.
- R4: On an edge where the run bit is set, interrupt enable (address 4, bit 0) is set and the count equals the match register (address 3), the pending flag sets and the interrupt output is high after that edge. With start value S and match value C, the output rises after the (C-S mod 2^32)+1-th edge that follows the edge committing the run bit.
- R5: A read of address 4 returns pending in bit 1 and enable in bit 0, with the values they held before the read. It clears the pending flag and drops the interrupt output after the same edge.
- R6: If a match occurs on the same edge as the acknowledging read, the pending flag and interrupt output stay set.
- R7: Clearing the interrupt enable drops the interrupt output after that edge. A pending flag that is already set stays set and reads back in bit 1.
- R8: Read data appears on the edge that samples the read strobe. Count reads do not disturb counting, writes to the count address have no effect, and unmapped addresses read as 0.
- R9: Synchronous reset clears every register and the counter, and drives the interrupt output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (3) | Word address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | W (32) | Write data |
| bus_ren | input | 1 | Read strobe |
| bus_rdata | output | W (32) | Registered read data |
| irq_o | output | 1 | Registered match interrupt |

## Verification
The bench aims at the counter's wrap:
- A scheduled match whose sum overflows would never fire in a design that compares with a magnitude test or saturates the counter.
- A start value of all-ones would show a stuck or skipped zero.

It also times the acknowledging read to land on the match edge itself. A design that gives the clear priority would lose that event.

Other directed cases cover the following:
- Masking with a pending flag kept, where a design that clears the flag on disable would read back 0.
- A stopped counter parked on the match value, where a design that ignores the run bit would raise a spurious interrupt.
- A write to the count address, where a design that decodes it would corrupt the time base.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_BITS = 3;

  localparam logic [ADDR_BITS-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_BITS-1:0] A_START = 3'd1;
  localparam logic [ADDR_BITS-1:0] A_COUNT = 3'd2;
  localparam logic [ADDR_BITS-1:0] A_MATCH = 3'd3;
  localparam logic [ADDR_BITS-1:0] A_IRQ   = 3'd4;

  localparam int RUN_BIT  = 0;
  localparam int IEN_BIT  = 0;
  localparam int PEND_BIT = 1;
endpackage

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = ADDR_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          wen,
  input  logic [W-1:0]  wdata,
  input  logic          ren,
  input  logic [W-1:0]  cnt,
  input  logic          pend,
  output logic          run,
  output logic [W-1:0]  start,
  output logic [W-1:0]  cmp,
  output logic          ien,
  output logic          ien_nxt,
  output logic          ack,
  output logic [W-1:0]  rdata
);
  logic          wr_ctrl, wr_start, wr_match, wr_irq;
  logic [W-1:0]  rd_mux;

  assign wr_ctrl  = wen && (addr == A_CTRL);
  assign wr_start = wen && (addr == A_START);
  assign wr_match = wen && (addr == A_MATCH);
  assign wr_irq   = wen && (addr == A_IRQ);
  assign ack      = ren && (addr == A_IRQ);
  assign ien_nxt  = wr_irq ? wdata[IEN_BIT] : ien;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      start <= '0;
      cmp   <= '0;
      ien   <= 1'b0;
    end else begin
      if (wr_ctrl)  run   <= wdata[RUN_BIT];
      if (wr_start) start <= wdata;
      if (wr_match) cmp   <= wdata;
      ien <= ien_nxt;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:  rd_mux[RUN_BIT] = run;
      A_START: rd_mux = start;
      A_COUNT: rd_mux = cnt;
      A_MATCH: rd_mux = cmp;
      A_IRQ: begin
        rd_mux[IEN_BIT]  = ien;
        rd_mux[PEND_BIT] = pend;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      rdata <= '0;
    else if (ren) rdata <= rd_mux;
  end
endmodule

// File: rtl/cmp_timer_counter.sv
module cmp_timer_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] start,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] STEP = W'(1);

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (run) cnt <= cnt + STEP;
    else          cnt <= start;
  end
endmodule

// File: rtl/cmp_timer_irq.sv
module cmp_timer_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         ien,
  input  logic         ien_nxt,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic         ack,
  output logic         pend,
  output logic         irq
);
  logic hit, pend_d;

  assign hit    = run && ien && (cnt == cmp);
  assign pend_d = hit || (pend && !ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_d;
      irq  <= pend_d && ien_nxt;
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = ADDR_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wen,
  input  logic [W-1:0]  bus_wdata,
  input  logic          bus_ren,
  output logic [W-1:0]  bus_rdata,
  output logic          irq_o
);
  logic [W-1:0] cnt_w, start_w, cmp_w;
  logic         run_w, ien_w, ien_nxt_w, ack_w, pend_w;

  cmp_timer_regs #(.W(W), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wen(bus_wen), .wdata(bus_wdata),
    .ren(bus_ren), .cnt(cnt_w), .pend(pend_w), .run(run_w), .start(start_w),
    .cmp(cmp_w), .ien(ien_w), .ien_nxt(ien_nxt_w), .ack(ack_w),
    .rdata(bus_rdata)
  );

  cmp_timer_counter #(.W(W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_w), .start(start_w), .cnt(cnt_w)
  );

  cmp_timer_irq #(.W(W)) u_irq (
    .clk(clk), .rst(rst), .run(run_w), .ien(ien_w), .ien_nxt(ien_nxt_w),
    .cnt(cnt_w), .cmp(cmp_w), .ack(ack_w), .pend(pend_w), .irq(irq_o)
  );
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk
  import cmp_timer_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = ADDR_BITS
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic          bus_ren,
  input logic          irq_o,
  input logic [W-1:0]  cnt,
  input logic [W-1:0]  start,
  input logic [W-1:0]  cmp,
  input logic          run,
  input logic          ien,
  input logic          pend
);
  logic live_hit, rd_irq;
  assign live_hit = run && ien && (cnt == cmp);
  assign rd_irq   = bus_ren && (bus_addr == A_IRQ);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    run |=> cnt == $past(cnt) + W'(1)); // R1
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!run && !pend) |=> !irq_o); // R2
  AST_STOPPED_LOAD: assert property (@(posedge clk) disable iff (rst)
    !run |=> cnt == $past(start)); // R3
  AST_MATCH_FIRES: assert property (@(posedge clk) disable iff (rst)
    live_hit |=> pend); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_irq && !live_hit) |=> !pend && !irq_o); // R5
  AST_ACK_RACE: assert property (@(posedge clk) disable iff (rst)
    (rd_irq && live_hit) |=> pend); // R6
  AST_MASKED: assert property (@(posedge clk) disable iff (rst)
    !ien |-> !irq_o); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cnt == '0) && !irq_o && !pend); // R9
endmodule

bind cmp_timer cmp_timer_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_ren(bus_ren), .irq_o(irq_o),
  .cnt(cnt_w), .start(start_w), .cmp(cmp_w), .run(run_w), .ien(ien_w),
  .pend(pend_w)
);

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  localparam int W = 32;
  localparam int AW = 3;
  localparam int NV = 5;
  // {start, match, expected edge count until irq}
  localparam logic [95:0] VEC [NV] = '{
    {32'd0,          32'd5,    32'd6},
    {32'd10,         32'd10,   32'd1},
    {32'hFFFF_FFF0,  32'd5,    32'd22},
    {32'hFFFF_FFFF,  32'd0,    32'd2},
    {32'd1000,       32'd1040, 32'd41}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wen = 1'b0;
  logic [W-1:0]  bus_wdata = '0;
  logic          bus_ren = 1'b0;
  logic [W-1:0]  bus_rdata;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  cmp_timer uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_ren(bus_ren), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    bus_addr = a; bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] v, v2;
    int n;
    idle(3);
    rst = 1'b0;
    // R9: reset state
    check("R9 irq", W'(irq_o), 0);
    rd(3'd2, v); check("R9 count", v, 0);
    rd(3'd4, v); check("R9 irq reg", v, 0);
    rd(3'd3, v); check("R9 match", v, 0);

    // R4: scheduled events from the vector table, including wrap
    for (int k = 0; k < NV; k++) begin
      wr(3'd0, 0);
      wr(3'd1, VEC[k][95:64]);
      wr(3'd3, VEC[k][63:32]);
      wr(3'd4, 1);
      rd(3'd4, v);
      wr(3'd0, 1);
      n = 0;
      while (!irq_o && n < 100) begin
        @(negedge clk);
        n++;
      end
      check("R4 match delay", W'(n), VEC[k][31:0]);
      rd(3'd4, v);
      check("R5 ack readback", v, 3);
      check("R5 irq dropped", W'(irq_o), 0);
    end

    // R2 / R3 / R8: stopped counter parked on match value
    wr(3'd0, 0);
    wr(3'd1, 32'h55);
    wr(3'd3, 32'h55);
    wr(3'd2, 32'h1234);
    idle(1);
    rd(3'd2, v);  check("R3 loaded", v, 32'h55);
    rd(3'd2, v);  check("R8 count write ignored", v, 32'h55);
    idle(5);
    check("R2 no match while stopped", W'(irq_o), 0);
    rd(3'd7, v);  check("R8 unmapped", v, 0);
    wr(3'd0, 1);
    rd(3'd2, v);  check("R3 resume first", v, 32'h55);
    rd(3'd2, v2); check("R3 resume next", v2, 32'h56);
    rd(3'd4, v);  // clear the match that fires at 0x55

    // R1: wrap through zero
    wr(3'd0, 0);
    wr(3'd1, 32'hFFFF_FFFE);
    idle(1);
    wr(3'd0, 1);
    rd(3'd2, v);  check("R1 before wrap", v, 32'hFFFF_FFFE);
    rd(3'd2, v);  check("R1 all ones", v, 32'hFFFF_FFFF);
    rd(3'd2, v);  check("R1 wrapped", v, 0);

    // R6: acknowledging read lands on the match edge
    wr(3'd0, 0);
    wr(3'd1, 32'd100);
    wr(3'd3, 32'd103);
    rd(3'd4, v);
    wr(3'd0, 1);
    idle(3);
    rd(3'd4, v);
    check("R6 read before latch", v, 1);
    check("R6 irq kept", W'(irq_o), 1);
    rd(3'd4, v);
    check("R6 pending kept", v, 3);

    // R7: masking keeps the pending flag
    wr(3'd0, 0);
    wr(3'd1, 32'd200);
    wr(3'd3, 32'd202);
    wr(3'd0, 1);
    idle(4);
    check("R7 irq before mask", W'(irq_o), 1);
    wr(3'd4, 0);
    check("R7 masked", W'(irq_o), 0);
    rd(3'd4, v);  check("R7 pending visible", v, 2);
    rd(3'd4, v);  check("R7 cleared by read", v, 0);

    // R9: reset mid-run
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    rd(3'd0, v);  check("R9 run cleared", v, 0);
    rd(3'd1, v);  check("R9 start cleared", v, 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule